// File: doc/BRIEF.md
# Pattern Apply-Compare Test Sequencer

This block is a small on-chip tester engine. It holds a short list of test patterns, each made of a stimulus, an expected response and a per-bit care mask. It runs them one after another against a built-in target: a single storage flop with true and complementary outputs. Each pattern goes through four steps. The stimulus is driven, one capture edge is given to the target, the target's response is sampled, and the sampled value is compared with the expected one. When the run ends, the block reports a die verdict: pass or fail, plus a numbered bin.

The target has a selectable fault injector. It can force the flop output low or high, or force a spare internal node that no pattern drives or observes. With it, a fault that the patterns catch and a fault that slips past them can both be shown on the same hardware. Patterns are written through a simple load port while the engine is idle. A run starts with a single-cycle start pulse.

Top module: `pattern_tester`

## Requirements
- R1: Each pattern takes exactly four cycles in a fixed order: apply the stimulus, give one target capture edge, sample the response, compare. The first log strobe comes in the fourth cycle after the cycle in which start is sampled, and a run of N patterns raises done in cycle 4N+1.
- R2: The response vector has the flop output in bit 0 and its complement in bit 1. A pattern mismatches only if some bit whose care-mask bit is 1 differs from the expected value. Bits with mask 0 never cause a mismatch.
- R3: Done and the verdict appear only after the run has ended. They are held, unchanged, until the next accepted start, and busy and done are never high together. A start pulse received while busy is ignored.
- R4: A run with no mismatch ends with pass=1 and bin=1, and fail_idx reads 0.
- R5: A run stops at the first mismatch and goes straight to the verdict: pass=0, bin=7, and fail_idx set to that pattern's index. No later pattern is applied.
- R6: For every pattern compared, log_vld pulses for one cycle. During that cycle log_idx, log_exp, log_cap and log_match show the pattern index, the expected value, the captured response and the match result.
- R7: fault_sel selects the injected fault: 0 none, 1 flop output stuck at 0, 2 flop output stuck at 1, 3 spare internal node stuck at 1 (this node reaches no response bit).
- R8: With the two-pattern reference list (d=1 expecting q=1, then d=0 expecting q=0, full mask), faults 0 and 3 give pass with bin 1. Fault 1 fails at pattern 0 and fault 2 fails at pattern 1, both with bin 7.
- R9: A start with pat_count=0 gives pass with bin 1 in the next cycle and produces no log strobe.
- R10: After reset, busy, done, pass, log_vld and bin are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle run request |
| pat_count | input | AW+1 | Number of patterns to run |
| ld_en | input | 1 | Pattern write enable |
| ld_addr | input | AW | Pattern write index |
| ld_stim | input | 1 | Stimulus bit for the entry |
| ld_exp | input | 2 | Expected response for the entry |
| ld_mask | input | 2 | Care mask for the entry |
| fault_sel | input | 2 | Injected fault select |
| busy | output | 1 | Run in progress |
| done | output | 1 | Verdict valid |
| pass | output | 1 | Die passed |
| bin | output | BIN_W | Bin code |
| fail_idx | output | AW | Index of the failing pattern |
| log_vld | output | 1 | Per-pattern log strobe |
| log_idx | output | AW | Logged pattern index |
| log_exp | output | 2 | Logged expected response |
| log_cap | output | 2 | Logged captured response |
| log_match | output | 1 | Logged match result |

## Verification
The assertions assume that fault_sel, pat_count and the pattern store stay still while busy is high, and that pat_count never exceeds the store depth. The bench changes the fault select and loads patterns only between runs, after done has been seen, and sets each count to at most the number of entries it has written. The one start pulse sent during a run is there on purpose, to show that it is ignored.

// File: rtl/pts_pkg.sv
// Package: shared types for the pattern test sequencer.
// Assumes: nothing; holds only the state encoding and fault codes.
package pts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_PULSE,
        ST_CAPTURE,
        ST_COMPARE,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] FLT_NONE   = 2'd0;
    localparam logic [1:0] FLT_Q_SA0  = 2'd1;
    localparam logic [1:0] FLT_Q_SA1  = 2'd2;
    localparam logic [1:0] FLT_HIDDEN = 2'd3;

endpackage

// File: rtl/pts_pat_store.sv
// Module: pattern store. Holds DEPTH entries of stimulus, expected
// response and care mask. Has one write port and one combinational read port.
// Assumes: writes happen only while the sequencer is idle.
module pts_pat_store #(
    parameter int DEPTH  = 8,
    parameter int STIM_W = 1,
    parameter int RESP_W = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [STIM_W-1:0] wr_stim,
    input  logic [RESP_W-1:0] wr_exp,
    input  logic [RESP_W-1:0] wr_mask,
    input  logic [AW-1:0]     rd_addr,
    output logic [STIM_W-1:0] rd_stim,
    output logic [RESP_W-1:0] rd_exp,
    output logic [RESP_W-1:0] rd_mask
);

    logic [STIM_W-1:0] stim_q [DEPTH];
    logic [RESP_W-1:0] exp_q  [DEPTH];
    logic [RESP_W-1:0] mask_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Entry register: cleared on reset, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stim_q[e] <= '0;
                exp_q[e]  <= '0;
                mask_q[e] <= '0;
            end else if (wr_en && wr_addr == AW'(e)) begin
                stim_q[e] <= wr_stim;
                exp_q[e]  <= wr_exp;
                mask_q[e] <= wr_mask;
            end
        end
    end

    // Read mux: entry selected by the sequencer's pattern index.
    always_comb begin
        rd_stim = stim_q[rd_addr];
        rd_exp  = exp_q[rd_addr];
        rd_mask = mask_q[rd_addr];
    end

endmodule

// File: rtl/pts_fault_target.sv
// Module: one-flop device under test with a fault injector.
// resp[0] is the flop output and resp[1] its complement, both after
// fault forcing. A spare flop stands for an internal node that reaches
// no response bit.
// Assumes: fault_sel is stable during a run.
module pts_fault_target (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en,
    input  logic       d,
    input  logic [1:0] fault_sel,
    output logic [1:0] resp
);
    import pts_pkg::*;

    logic q_r;
    logic spare_r;
    logic q_out;
    logic spare_node;

    // Storage flop and spare node: update only on the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r     <= 1'b0;
            spare_r <= 1'b0;
        end else if (cap_en) begin
            q_r     <= d;
            spare_r <= ~d;
        end
    end

    // Fault forcing on the output net and on the spare node.
    always_comb begin
        unique case (fault_sel)
            FLT_Q_SA0: q_out = 1'b0;
            FLT_Q_SA1: q_out = 1'b1;
            default:   q_out = q_r;
        endcase
        spare_node = (fault_sel == FLT_HIDDEN) ? 1'b1 : spare_r;
        resp = {~q_out, q_out};
    end

    // R7: with no fault, the observed output follows the last captured d
    a_r7_no_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sel == FLT_NONE) && $past(cap_en) |-> resp[0] == $past(d));
    // R7: stuck-at-0 holds the output low
    a_r7_sa0_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sel == FLT_Q_SA0) |-> resp == 2'b10);
    // R7: the hidden fault forces only the spare node and leaves the response alone
    a_r7_hidden_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sel == FLT_HIDDEN) |-> spare_node && resp[0] == q_r);

endmodule

// File: rtl/pts_seq_fsm.sv
// Module: apply/pulse/capture/compare sequencer with verdict and bin.
// Steps through pat_count entries and stops at the first masked mismatch.
// Issues a log strobe per compared pattern and holds the verdict until
// the next start.
// Assumes: pat_count <= DEPTH, and the store and count are stable while busy.
module pts_seq_fsm #(
    parameter int DEPTH    = 8,
    parameter int STIM_W   = 1,
    parameter int RESP_W   = 2,
    parameter int BIN_W    = 4,
    parameter int BIN_PASS = 1,
    parameter int BIN_FAIL = 7,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW:0]       pat_count,
    input  logic [STIM_W-1:0] ent_stim,
    input  logic [RESP_W-1:0] ent_exp,
    input  logic [RESP_W-1:0] ent_mask,
    input  logic [RESP_W-1:0] resp,
    output logic [AW-1:0]     rd_addr,
    output logic [STIM_W-1:0] stim_drv,
    output logic              cap_en,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [BIN_W-1:0]  bin,
    output logic [AW-1:0]     fail_idx,
    output logic              log_vld,
    output logic [AW-1:0]     log_idx,
    output logic [RESP_W-1:0] log_exp,
    output logic [RESP_W-1:0] log_cap,
    output logic              log_match
);
    import pts_pkg::*;

    seq_state_t        state_q;
    logic [AW-1:0]     idx_q;
    logic [STIM_W-1:0] stim_q;
    logic [RESP_W-1:0] cap_q;
    logic              pass_q;
    logic [BIN_W-1:0]  bin_q;
    logic [AW-1:0]     fidx_q;
    logic              hit;
    logic              last;

    // Compare decode: masked difference and last-pattern test.
    always_comb begin
        hit  = ((cap_q ^ ent_exp) & ent_mask) == '0;
        last = ({1'b0, idx_q} + (AW+1)'(1)) == pat_count;
    end

    // Sequencer state, pattern index and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            stim_q  <= '0;
            cap_q   <= '0;
            pass_q  <= 1'b0;
            bin_q   <= '0;
            fidx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        idx_q  <= '0;
                        fidx_q <= '0;
                        if (pat_count == '0) begin
                            state_q <= ST_DONE;
                            pass_q  <= 1'b1;
                            bin_q   <= BIN_W'(BIN_PASS);
                        end else begin
                            state_q <= ST_APPLY;
                        end
                    end
                end
                ST_APPLY: begin
                    stim_q  <= ent_stim;
                    state_q <= ST_PULSE;
                end
                ST_PULSE: begin
                    state_q <= ST_CAPTURE;
                end
                ST_CAPTURE: begin
                    cap_q   <= resp;
                    state_q <= ST_COMPARE;
                end
                ST_COMPARE: begin
                    if (!hit) begin
                        state_q <= ST_DONE;
                        pass_q  <= 1'b0;
                        bin_q   <= BIN_W'(BIN_FAIL);
                        fidx_q  <= idx_q;
                    end else if (last) begin
                        state_q <= ST_DONE;
                        pass_q  <= 1'b1;
                        bin_q   <= BIN_W'(BIN_PASS);
                    end else begin
                        idx_q   <= idx_q + AW'(1);
                        state_q <= ST_APPLY;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        rd_addr   = idx_q;
        stim_drv  = stim_q;
        cap_en    = (state_q == ST_PULSE);
        busy      = (state_q == ST_APPLY) || (state_q == ST_PULSE) ||
                    (state_q == ST_CAPTURE) || (state_q == ST_COMPARE);
        done      = (state_q == ST_DONE);
        pass      = done && pass_q;
        bin       = done ? bin_q : '0;
        fail_idx  = done ? fidx_q : '0;
        log_vld   = (state_q == ST_COMPARE);
        log_idx   = idx_q;
        log_exp   = ent_exp;
        log_cap   = cap_q;
        log_match = hit;
    end

    // R1: the capture edge lasts exactly one cycle
    a_r1_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !cap_en);
    // R1: compare comes two cycles after the capture edge
    a_r1_compare_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        log_vld |-> $past(cap_en, 2));
    // R3: no verdict while a run is in progress
    a_r3_no_midrun_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    // R3: verdict held until the next start
    a_r3_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(bin) && $stable(pass) && $stable(fail_idx));
    // R4: a passing die carries the pass bin
    a_r4_pass_bin: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> bin == BIN_W'(BIN_PASS));
    // R5: a mismatch ends the run with the logic-fail bin at that index
    a_r5_stop_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        log_vld && !log_match |=> done && !pass && bin == BIN_W'(BIN_FAIL)
                                  && fail_idx == $past(log_idx));

endmodule

// File: rtl/pattern_tester.sv
// Module: top of the pattern apply-compare test sequencer. Connects the
// pattern store, the sequencer and the fault-injectable one-flop target.
// Assumes: loads and fault_sel changes happen only while busy is low.
module pattern_tester #(
    parameter int DEPTH    = 8,
    parameter int BIN_W    = 4,
    parameter int BIN_PASS = 1,
    parameter int BIN_FAIL = 7,
    localparam int AW      = $clog2(DEPTH),
    localparam int STIM_W  = 1,
    localparam int RESP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW:0]       pat_count,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [STIM_W-1:0] ld_stim,
    input  logic [RESP_W-1:0] ld_exp,
    input  logic [RESP_W-1:0] ld_mask,
    input  logic [1:0]        fault_sel,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [BIN_W-1:0]  bin,
    output logic [AW-1:0]     fail_idx,
    output logic              log_vld,
    output logic [AW-1:0]     log_idx,
    output logic [RESP_W-1:0] log_exp,
    output logic [RESP_W-1:0] log_cap,
    output logic              log_match
);

    logic [AW-1:0]     rd_addr;
    logic [STIM_W-1:0] ent_stim;
    logic [RESP_W-1:0] ent_exp;
    logic [RESP_W-1:0] ent_mask;
    logic [STIM_W-1:0] stim_drv;
    logic              cap_en;
    logic [RESP_W-1:0] resp;

    pts_pat_store #(.DEPTH(DEPTH), .STIM_W(STIM_W), .RESP_W(RESP_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ld_en), .wr_addr(ld_addr), .wr_stim(ld_stim),
        .wr_exp(ld_exp), .wr_mask(ld_mask),
        .rd_addr(rd_addr), .rd_stim(ent_stim), .rd_exp(ent_exp), .rd_mask(ent_mask)
    );

    pts_seq_fsm #(
        .DEPTH(DEPTH), .STIM_W(STIM_W), .RESP_W(RESP_W), .BIN_W(BIN_W),
        .BIN_PASS(BIN_PASS), .BIN_FAIL(BIN_FAIL)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
        .ent_stim(ent_stim), .ent_exp(ent_exp), .ent_mask(ent_mask), .resp(resp),
        .rd_addr(rd_addr), .stim_drv(stim_drv), .cap_en(cap_en),
        .busy(busy), .done(done), .pass(pass), .bin(bin), .fail_idx(fail_idx),
        .log_vld(log_vld), .log_idx(log_idx), .log_exp(log_exp),
        .log_cap(log_cap), .log_match(log_match)
    );

    pts_fault_target u_target (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .d(stim_drv[0]),
        .fault_sel(fault_sel), .resp(resp)
    );

    // R10: nothing is reported straight after reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> !busy && !done && !log_vld && bin == '0);

endmodule

// File: tb/pattern_tester_tb.sv
module pattern_tester_tb;

    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW:0]   pat_count = '0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_stim = 1'b0;
    logic [1:0]    ld_exp = '0;
    logic [1:0]    ld_mask = '0;
    logic [1:0]    fault_sel = '0;
    logic          busy, done, pass, log_vld, log_match;
    logic [3:0]    bin;
    logic [AW-1:0] fail_idx, log_idx;
    logic [1:0]    log_exp, log_cap;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Run results gathered by the run task
    int            n_logs;
    int            first_log_k;
    int            done_k;
    logic [AW-1:0] lg_idx [8];
    logic [1:0]    lg_cap [8];
    logic [1:0]    lg_exp [8];
    logic          lg_match [8];

    always #2 clk = ~clk;

    pattern_tester u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_stim(ld_stim), .ld_exp(ld_exp),
        .ld_mask(ld_mask), .fault_sel(fault_sel),
        .busy(busy), .done(done), .pass(pass), .bin(bin), .fail_idx(fail_idx),
        .log_vld(log_vld), .log_idx(log_idx), .log_exp(log_exp),
        .log_cap(log_cap), .log_match(log_match)
    );

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic load(input int a, input bit s, input logic [1:0] e, input logic [1:0] m);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(a); ld_stim = s; ld_exp = e; ld_mask = m;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Pulse start, optionally poke start again mid-run, collect logs until done
    task automatic run(input int cnt, input bit poke);
        n_logs = 0; first_log_k = -1; done_k = -1;
        @(negedge clk);
        pat_count = (AW+1)'(cnt);
        start = 1'b1;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            start = (poke && k == 2) ? 1'b1 : 1'b0;
            if (log_vld) begin
                if (first_log_k < 0) first_log_k = k;
                if (n_logs < 8) begin
                    lg_idx[n_logs] = log_idx; lg_cap[n_logs] = log_cap;
                    lg_exp[n_logs] = log_exp; lg_match[n_logs] = log_match;
                end
                n_logs++;
            end
            if (done && !start) begin
                done_k = k;
                break;
            end
        end
        start = 1'b0;
        chk(done_k > 0, "R3 run reached done", done_k, 1);
    endtask

    // Vector table: {fault_sel, exp_pass, exp_bin, exp_fail_idx} for the reference list (R8)
    localparam logic [7:0] VEC [4] = '{
        {2'd0, 1'b1, 4'd1, 1'b0},
        {2'd1, 1'b0, 4'd7, 1'b0},
        {2'd2, 1'b0, 4'd7, 1'b1},
        {2'd3, 1'b1, 4'd1, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !done && !pass && !log_vld && bin == 0, "R10 reset outputs quiet",
            int'({busy, done, pass, log_vld}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && bin == 0, "R10 idle after reset", int'(bin), 0);

        // Reference list: resp = {qn, q}
        load(0, 1'b1, 2'b01, 2'b11);
        load(1, 1'b0, 2'b10, 2'b11);

        foreach (VEC[i]) begin
            fault_sel = VEC[i][7:6];
            run(2, 1'b0);
            chk(pass == VEC[i][5], $sformatf("R8 pass fault=%0d", VEC[i][7:6]), int'(pass), int'(VEC[i][5]));
            chk(bin == VEC[i][4:1], $sformatf("R8 bin fault=%0d", VEC[i][7:6]), int'(bin), int'(VEC[i][4:1]));
            chk(fail_idx == AW'(VEC[i][0]), "R5 fail index", int'(fail_idx), int'(VEC[i][0]));
            if (VEC[i][5]) begin
                chk(n_logs == 2, "R4 all patterns logged", n_logs, 2);
                chk(done_k == 9, "R1 two-pattern run length", done_k, 9);
                chk(fail_idx == 0, "R4 fail_idx zero on pass", int'(fail_idx), 0);
            end else begin
                chk(n_logs == int'(VEC[i][0]) + 1, "R5 stop at first mismatch", n_logs, int'(VEC[i][0]) + 1);
            end
        end

        // R1 / R6: timing and log contents, no fault
        fault_sel = 2'd0;
        run(2, 1'b0);
        chk(first_log_k == 4, "R1 first log in fourth cycle", first_log_k, 4);
        chk(lg_idx[0] == 0 && lg_idx[1] == 1, "R6 log indices", int'(lg_idx[1]), 1);
        chk(lg_cap[0] == 2'b01 && lg_exp[0] == 2'b01 && lg_match[0], "R6 log pattern 0",
            int'(lg_cap[0]), 1);
        chk(lg_cap[1] == 2'b10 && lg_exp[1] == 2'b10 && lg_match[1], "R6 log pattern 1",
            int'(lg_cap[1]), 2);

        // R6: mismatch log contents under stuck-at-0
        fault_sel = 2'd1;
        run(2, 1'b0);
        chk(lg_cap[0] == 2'b10 && !lg_match[0], "R6 mismatch logged", int'(lg_cap[0]), 2);

        // R3: verdict held while idle with no start
        repeat (5) @(negedge clk);
        chk(done && bin == 7 && !pass, "R3 verdict held", int'(bin), 7);

        // R2: a wrong expected bit under mask 0 is ignored; under mask 1 it fails
        fault_sel = 2'd0;
        load(0, 1'b1, 2'b11, 2'b01);
        run(1, 1'b0);
        chk(pass && bin == 1, "R2 masked bit ignored", int'(bin), 1);
        load(0, 1'b1, 2'b11, 2'b10);
        run(1, 1'b0);
        chk(!pass && bin == 7, "R2 cared bit compared", int'(bin), 7);

        // R5: longer list failing at pattern 2
        load(0, 1'b1, 2'b01, 2'b11);
        load(1, 1'b0, 2'b10, 2'b11);
        load(2, 1'b1, 2'b10, 2'b11);
        load(3, 1'b0, 2'b10, 2'b11);
        run(4, 1'b0);
        chk(fail_idx == 2 && bin == 7, "R5 fail at index 2", int'(fail_idx), 2);
        chk(n_logs == 3, "R5 later patterns not applied", n_logs, 3);

        // R3: start while busy ignored
        run(2, 1'b1);
        chk(done_k == 9 && n_logs == 2, "R3 busy start ignored", done_k, 9);
        chk(pass && bin == 1, "R3 run unaffected by busy start", int'(bin), 1);

        // R9: empty list
        run(0, 1'b0);
        chk(done_k == 1 && n_logs == 0, "R9 empty list immediate", done_k, 1);
        chk(pass && bin == 1, "R9 empty list passes", int'(bin), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule